// File: doc/BRIEF.md
# Pipelined AES-128 Encryption Datapath

This block is the forward AES-128 cipher unrolled into a straight pipeline. Each clock it can accept one 128-bit plaintext block, qualified by a valid flag. It also takes all eleven expanded 128-bit round keys on one wide parallel bus. An input register applies the first key addition. Each of the ten rounds then has its own logic and its own register, so once the pipeline has filled, one ciphertext block comes out every clock with a matching valid flag.

Key expansion, decryption and any chaining or counter mode belong to the surrounding logic. The round-key bus is treated as static while blocks are in flight. A user that changes keys drains the pipeline first.

Each round substitutes bytes through sixteen parallel copies of the byte substitution table. It then rotates the state rows by plain rewiring, mixes the four columns in four parallel units built from a multiply-by-two primitive, and adds the round key. The tenth round has no column mixing. Reset is asynchronous and active-low, and it is expected to be released in step with the clock. Reset clears only the valid flags. The data registers are loaded only when the valid flag beside them is set.

Top module: `aes128_pipe_enc`

## Requirements
- R1: `ct_out` is the AES-128 encryption of the accepted `pt_in` under the expanded key on `rk_in`. The state is mapped column-major: byte 0 of the state is `pt_in[127:120]` and byte 15 is `pt_in[7:0]`, so the standard published test vectors reproduce bit for bit.
- R2: Round key i (0 to 10) is read from `rk_in[128*i +: 128]`. Round key 0 is added to the plaintext before the first round.
- R3: A block accepted at rising edge k (with `in_valid` high) appears on `ct_out` with `out_valid` high right after rising edge k+10. The latency is 11 clocks.
- R4: Blocks offered on consecutive clocks leave on consecutive clocks, in the same order, with no lost or repeated block.
- R5: `out_valid` reproduces the `in_valid` pattern delayed by 11 clocks, gaps included. No output is flagged valid without a matching accepted input.
- R6: While `rst_n` is low, `out_valid` is low. It stays low after release until an accepted block has crossed the pipeline.
- R7: With `in_valid` low, `pt_in` is ignored. No output is produced for it, and `ct_out` keeps its last value.
- R8: Asserting reset while blocks are in flight discards them. None of them ever appears with `out_valid` high after reset is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| in_valid | input | 1 | Qualifies `pt_in` this cycle |
| pt_in | input | 128 | Plaintext block, byte 0 in the top bits |
| rk_in | input | 1408 | Eleven round keys, key i at bits 128*i upward |
| out_valid | output | 1 | Qualifies `ct_out` |
| ct_out | output | 128 | Ciphertext block |

## Verification
A fault in any round's substitution, row rotation, column mixing or key addition corrupts every block that passes through that round. The full 128-bit result then differs from the published vectors exactly 11 clocks after the block is offered. A stuck or misrouted valid bit shows up as a missing, shifted or extra `out_valid` pulse, which is caught against the delayed input pattern on the very cycle it is due. Back-to-back blocks, blocks separated by gaps, reset with a full pipeline, and idle cycles that carry junk plaintext are all driven, so ordering, bubble handling and data-hold faults reach the ports within one pipeline length.

// File: rtl/aes_pipe_pkg.sv
package aes_pipe_pkg;
  localparam int BYTE_W  = 8;
  localparam int BLK_W   = 128;
  localparam int NBYTES  = BLK_W / BYTE_W;
  localparam int NCOLS   = 4;
  localparam int COL_W   = BLK_W / NCOLS;
  localparam int NR      = 10;
  localparam int RK_W    = BLK_W * (NR + 1);
  localparam int LAT     = NR + 1;

  typedef logic [BYTE_W-1:0] byte_t;
  typedef logic [BLK_W-1:0]  block_t;

  // multiply by x in GF(2^8) modulo x^8+x^4+x^3+x+1
  function automatic byte_t xtime(input byte_t a);
    return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
  endfunction

  function automatic byte_t gf_mul(input byte_t a, input byte_t b);
    byte_t p;
    byte_t aa;
    p  = '0;
    aa = a;
    for (int i = 0; i < BYTE_W; i++) begin
      if (b[i]) p = p ^ aa;
      aa = xtime(aa);
    end
    return p;
  endfunction

  // inverse as a^254 by square-and-multiply; zero maps to zero
  function automatic byte_t gf_inv(input byte_t a);
    byte_t r;
    byte_t base;
    logic [7:0] e;
    r    = 8'h01;
    base = a;
    e    = 8'hfe;
    for (int i = 0; i < BYTE_W; i++) begin
      if (e[i]) r = gf_mul(r, base);
      base = gf_mul(base, base);
    end
    return r;
  endfunction

  // one entry of the 256x8 substitution table
  function automatic byte_t sbox_f(input byte_t x);
    byte_t b;
    b = gf_inv(x);
    return b ^ {b[6:0], b[7]} ^ {b[5:0], b[7:6]} ^ {b[4:0], b[7:5]}
             ^ {b[3:0], b[7:4]} ^ 8'h63;
  endfunction
endpackage

// File: rtl/aes_sub_bank.sv
module aes_sub_bank
  import aes_pipe_pkg::*;
(
  input  block_t st_i,
  output block_t st_o
);
  for (genvar i = 0; i < NBYTES; i++) begin : g_lut
    byte_t lut_out;
    always_comb lut_out = sbox_f(st_i[BLK_W-1-BYTE_W*i -: BYTE_W]);
    assign st_o[BLK_W-1-BYTE_W*i -: BYTE_W] = lut_out;
  end
endmodule

// File: rtl/aes_mix_column.sv
module aes_mix_column
  import aes_pipe_pkg::*;
(
  input  logic [COL_W-1:0] col_i,
  output logic [COL_W-1:0] col_o
);
  byte_t b0, b1, b2, b3;
  byte_t d0, d1, d2, d3;

  assign b0 = col_i[31:24];
  assign b1 = col_i[23:16];
  assign b2 = col_i[15:8];
  assign b3 = col_i[7:0];

  always_comb begin
    d0 = xtime(b0);
    d1 = xtime(b1);
    d2 = xtime(b2);
    d3 = xtime(b3);
    col_o[31:24] = d0 ^ (d1 ^ b1) ^ b2 ^ b3;
    col_o[23:16] = b0 ^ d1 ^ (d2 ^ b2) ^ b3;
    col_o[15:8]  = b0 ^ b1 ^ d2 ^ (d3 ^ b3);
    col_o[7:0]   = (d0 ^ b0) ^ b1 ^ b2 ^ d3;
  end
endmodule

// File: rtl/aes_round_stage.sv
module aes_round_stage
  import aes_pipe_pkg::*;
#(
  parameter bit FINAL = 1'b0
)(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   v_i,
  input  block_t st_i,
  input  block_t rk_i,
  output logic   v_o,
  output block_t st_o
);
  block_t subd;
  block_t shifted;
  block_t mixed;
  block_t st_d;
  block_t st_q;
  logic   v_q;

  aes_sub_bank u_sub (.st_i(st_i), .st_o(subd));

  // row r of column c takes the byte of row r in column (c+r) mod 4
  for (genvar c = 0; c < NCOLS; c++) begin : g_col
    for (genvar r = 0; r < 4; r++) begin : g_row
      localparam int DST = 4 * c + r;
      localparam int SRC = 4 * ((c + r) % NCOLS) + r;
      assign shifted[BLK_W-1-BYTE_W*DST -: BYTE_W] = subd[BLK_W-1-BYTE_W*SRC -: BYTE_W];
    end
    if (FINAL) begin : g_nomix
      assign mixed[BLK_W-1-COL_W*c -: COL_W] = shifted[BLK_W-1-COL_W*c -: COL_W];
    end else begin : g_mix
      aes_mix_column u_mc (
        .col_i(shifted[BLK_W-1-COL_W*c -: COL_W]),
        .col_o(mixed[BLK_W-1-COL_W*c -: COL_W])
      );
    end
  end

  always_comb st_d = mixed ^ rk_i;

  always_ff @(posedge clk) begin
    if (v_i) st_q <= st_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) v_q <= 1'b0;
    else        v_q <= v_i;
  end

  assign v_o  = v_q;
  assign st_o = st_q;
endmodule

// File: rtl/aes128_pipe_enc.sv
module aes128_pipe_enc
  import aes_pipe_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [BLK_W-1:0]  pt_in,
  input  logic [RK_W-1:0]   rk_in,
  output logic              out_valid,
  output logic [BLK_W-1:0]  ct_out
);
  logic [NR:0] vld;
  block_t      st [NR+1];
  block_t      st0_d;

  // stage 0: whitening with round key 0
  always_comb st0_d = pt_in ^ rk_in[0 +: BLK_W];

  always_ff @(posedge clk) begin
    if (in_valid) st[0] <= st0_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld[0] <= 1'b0;
    else        vld[0] <= in_valid;
  end

  for (genvar r = 1; r <= NR; r++) begin : g_round
    aes_round_stage #(.FINAL(r == NR)) u_rnd (
      .clk  (clk),
      .rst_n(rst_n),
      .v_i  (vld[r-1]),
      .st_i (st[r-1]),
      .rk_i (rk_in[BLK_W*r +: BLK_W]),
      .v_o  (vld[r]),
      .st_o (st[r])
    );
  end

  assign out_valid = vld[NR];
  assign ct_out    = st[NR];
endmodule

// File: rtl/aes128_pipe_enc_chk.sv
module aes128_pipe_enc_chk
  import aes_pipe_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             out_valid,
  input logic [BLK_W-1:0] ct_out,
  input logic [NR:0]      vld
);
  logic [LAT-1:0] shadow;
  logic           seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow <= '0;
      seen   <= 1'b0;
    end else begin
      shadow <= {shadow[LAT-2:0], in_valid};
      if (out_valid) seen <= 1'b1;
    end
  end

  // R3 / R5: output flag equals input flag delayed by the full latency
  p_latency_r3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == shadow[LAT-1]);

  // R5: stage-0 flag follows the input flag one clock later
  p_capture_r5: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> vld[0]);

  p_nocapture_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !vld[0]);

  // R7: without a valid block in the last round, the output holds
  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && !vld[NR-1]) |=> $stable(ct_out));

  // R6 / R8: reset empties every stage
  p_reset_r6: assert property (@(posedge clk)
    !rst_n |-> (!out_valid && vld == '0));
endmodule

bind aes128_pipe_enc aes128_pipe_enc_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_valid (in_valid),
  .out_valid(out_valid),
  .ct_out   (ct_out),
  .vld      (vld)
);

// File: tb/aes128_pipe_enc_tb.sv
module aes128_pipe_enc_tb;
  import aes_pipe_pkg::*;

  localparam int CLK_P  = 10;
  localparam int NVEC   = 7;
  localparam int FIFO_D = 64;

  // each entry: {key, plaintext, ciphertext}
  localparam logic [383:0] VECS [NVEC] = '{
    {128'h00000000000000000000000000000000, 128'h00000000000000000000000000000000,
     128'h66e94bd4ef8a2c3b884cfa59ca342b2e},
    {128'h000102030405060708090a0b0c0d0e0f, 128'h00112233445566778899aabbccddeeff,
     128'h69c4e0d86a7b0430d8cdb78070b4c55a},
    {128'h2b7e151628aed2a6abf7158809cf4f3c, 128'h3243f6a8885a308d313198a2e0370734,
     128'h3925841d02dc09fbdc118597196a0b32},
    {128'h2b7e151628aed2a6abf7158809cf4f3c, 128'h6bc1bee22e409f96e93d7e117393172a,
     128'h3ad77bb40d7a3660a89ecaf32466ef97},
    {128'h2b7e151628aed2a6abf7158809cf4f3c, 128'hae2d8a571e03ac9c9eb76fac45af8e51,
     128'hf5d3d58503b9699de785895a96fdbaaf},
    {128'h2b7e151628aed2a6abf7158809cf4f3c, 128'h30c81c46a35ce411e5fbc1191a0a52ef,
     128'h43b1cd7f598ece23881b00e3ed030688},
    {128'h2b7e151628aed2a6abf7158809cf4f3c, 128'hf69f2445df4f9b17ad2b417be66c3710,
     128'h7b0c785e27e8ad3f8223207104725dd4}
  };

  logic              clk;
  logic              rst_n;
  logic              in_valid;
  logic [BLK_W-1:0]  pt_in;
  logic [RK_W-1:0]   rk_in;
  logic              out_valid;
  logic [BLK_W-1:0]  ct_out;

  int n_chk;
  int n_bad;
  int now;
  logic [BLK_W-1:0] exp_ct [FIFO_D];
  int               exp_t  [FIFO_D];
  int wr;
  int rd;

  aes128_pipe_enc u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .pt_in(pt_in),
    .rk_in(rk_in), .out_valid(out_valid), .ct_out(ct_out)
  );

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  // independent reference pieces for key expansion
  function automatic logic [7:0] m2(input logic [7:0] a);
    return (a << 1) ^ ((a & 8'h80) != 0 ? 8'h1b : 8'h00);
  endfunction

  function automatic logic [7:0] mulr(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] p = 8'h00;
    logic [7:0] t = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) p ^= t;
      t = m2(t);
    end
    return p;
  endfunction

  function automatic logic [7:0] ref_sub(input logic [7:0] a);
    logic [7:0] v = 8'h00;
    logic [7:0] s;
    for (int c = 1; c < 256; c++)
      if (mulr(a, 8'(c)) == 8'h01) v = 8'(c);
    s = 8'h63;
    for (int k = 0; k < 5; k++) s ^= (v << k) | (v >> (8 - k));
    return s;
  endfunction

  function automatic logic [RK_W-1:0] expand(input logic [127:0] key);
    logic [31:0] w [44];
    logic [31:0] t;
    logic [7:0]  rc = 8'h01;
    logic [RK_W-1:0] bus;
    for (int i = 0; i < 4; i++) w[i] = key[127-32*i -: 32];
    for (int i = 4; i < 44; i++) begin
      t = w[i-1];
      if (i % 4 == 0) begin
        t = {ref_sub(t[23:16]), ref_sub(t[15:8]), ref_sub(t[7:0]), ref_sub(t[31:24])}
            ^ {rc, 24'h0};
        rc = m2(rc);
      end
      w[i] = w[i-4] ^ t;
    end
    for (int r = 0; r <= NR; r++)
      bus[128*r +: 128] = {w[4*r], w[4*r+1], w[4*r+2], w[4*r+3]};
    return bus;
  endfunction

  task automatic check(input bit ok, input string req,
                       input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic monitor();
    if (out_valid) begin
      if (rd == wr) begin
        check(1'b0, "R5 unexpected out_valid", 128'(out_valid), 128'(0));
      end else begin
        check(ct_out == exp_ct[rd % FIFO_D], "R1/R4 ciphertext", ct_out, exp_ct[rd % FIFO_D]);
        check(now - exp_t[rd % FIFO_D] == LAT, "R3 latency",
              128'(now - exp_t[rd % FIFO_D]), 128'(LAT));
        rd++;
      end
    end else if (rd != wr && now - exp_t[rd % FIFO_D] >= LAT) begin
      check(1'b0, "R3 missing output", 128'(now - exp_t[rd % FIFO_D]), 128'(LAT));
      rd++;
    end
  endtask

  // one clock: observe at the falling edge, then drive the next inputs
  task automatic tick(input logic v, input logic [127:0] p, input logic [127:0] e);
    @(negedge clk);
    now++;
    monitor();
    in_valid = v;
    pt_in    = p;
    if (v) begin
      exp_ct[wr % FIFO_D] = e;
      exp_t[wr % FIFO_D]  = now;
      wr++;
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) tick(1'b0, {4{$urandom}}, '0);
  endtask

  initial begin
    #(CLK_P * 200000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [127:0] cur_key;
    logic [127:0] last;
    n_chk = 0; n_bad = 0; now = 0; wr = 0; rd = 0;
    in_valid = 1'b0;
    pt_in    = '0;
    rk_in    = '0;
    rst_n    = 1'b1;
    #2 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R6 reset state", 128'(out_valid), 128'(0));
    rst_n = 1'b1;
    idle(3);
    check(out_valid == 1'b0, "R6 idle after release", 128'(out_valid), 128'(0));

    // table walk: R1, R2, R3; vectors with a shared key run back to back (R4)
    cur_key = '1;
    for (int i = 0; i < NVEC; i++) begin
      if (VECS[i][383:256] != cur_key) begin
        idle(LAT + 2);
        cur_key = VECS[i][383:256];
        rk_in   = expand(cur_key);
      end
      tick(1'b1, VECS[i][255:128], VECS[i][127:0]);
    end
    idle(LAT + 2);

    // R5: same key, blocks separated by gaps of varying length
    for (int i = 2; i < NVEC; i++) begin
      tick(1'b1, VECS[i][255:128], VECS[i][127:0]);
      for (int g = 0; g < i - 2; g++) tick(1'b0, '0, '0);
    end
    idle(LAT + 2);
    check(rd == wr, "R5 all blocks delivered", 128'(rd), 128'(wr));

    // R7: junk plaintext with in_valid low changes nothing at the output
    last = ct_out;
    for (int i = 0; i < 15; i++) begin
      tick(1'b0, {4{$urandom}}, '0);
      check(out_valid == 1'b0 && ct_out == last, "R7 ignored input", ct_out, last);
    end

    // R8: reset with a full pipeline drops in-flight blocks
    for (int i = 3; i < NVEC; i++) tick(1'b1, VECS[i][255:128], VECS[i][127:0]);
    tick(1'b1, VECS[2][255:128], VECS[2][127:0]);
    @(negedge clk);
    now++;
    rst_n    = 1'b0;
    in_valid = 1'b0;
    rd       = wr;
    #1;
    check(out_valid == 1'b0, "R8 reset mid-stream", 128'(out_valid), 128'(0));
    repeat (2) @(negedge clk);
    now += 2;
    rst_n = 1'b1;
    for (int i = 0; i < LAT + 3; i++) begin
      tick(1'b0, '0, '0);
      check(out_valid == 1'b0, "R8 no stale block", 128'(out_valid), 128'(0));
    end

    // after the flush the pipeline works again (R1)
    tick(1'b1, VECS[3][255:128], VECS[3][127:0]);
    idle(LAT + 2);
    check(rd == wr, "R1 recovery block delivered", 128'(rd), 128'(wr));

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule